// File: doc/BRIEF.md
# Owner/Keeper Directory Controller

This block is the memory-side directory for a small group of caches (four by default). For each block of its internal memory it keeps one presence bit per cache and one Modified flag. A cache holding a block is either its single Owner, holding a dirty copy with Modified set, or one of possibly several Keepers, holding clean copies. Caches send four kinds of request: take ownership without data, take ownership with the memory copy, fetch a clean copy, and write a block back. The controller answers with invalidate or update-memory commands to the caches, then with a single response to the requester.

Only one transaction is in flight at a time. After a request is accepted, the controller looks up the directory entry. It issues the needed commands as a one-cycle pulse on a per-cache command vector, waits until every addressed cache has acknowledged, updates memory and the directory, and then returns the response. The state machine has five states. IDLE accepts a request (IDLE to LOOKUP). LOOKUP decides between SEND, when other caches must act, and GRANT, when none need to. SEND pulses the commands and always moves to WAIT. WAIT collects acknowledgements and moves to GRANT once none are pending. GRANT issues the response and returns to IDLE.

Top module: `dirctl_top`

## Requirements
- R1: After reset, req_ready is 1 and cmd_valid and rsp_valid are 0. The directory is empty, and memory block a holds 32'hA000_0000 | a.
- R2: A clean-copy request (req_kind 2) for a block with no Owner sends no command. It answers the requester (rsp_dst) with rsp_has_data 1 and the memory copy, and the requester becomes a Keeper.
- R3: An ownership request (req_kind 0) sends an invalidate (cmd_kind 0) to every other cache whose presence bit is set, and none to the requester. The response has rsp_has_data 0. The requester becomes the sole Owner.
- R4: An ownership-with-data request (req_kind 1) behaves as R3 and also returns the memory copy with rsp_has_data 1.
- R5: Commands are a one-cycle pulse. The response comes only after every addressed cache has raised ack_valid.
- R6: A clean-copy request while another cache owns the block sends one update-memory command (cmd_kind 1) to the Owner only. The data from the Owner's acknowledgement is written to memory and returned to the requester. The former Owner stays present as a Keeper and Modified clears.
- R7: A writeback (req_kind 3) from the Owner stores req_data into memory and removes that cache from the directory. The response has rsp_has_data 0.
- R8: A writeback from a cache that is not the Owner changes neither memory nor the directory.
- R9: req_ready is 0 from the cycle after a request is accepted until the response has been given.
- R10: A request from the block's current Owner sends no command. An ownership request leaves it Owner. A clean-copy request returns the memory copy and leaves it Owner.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_src | input | 2 | Requesting cache index |
| req_kind | input | 2 | 0 own, 1 own with data, 2 clean copy, 3 writeback |
| req_addr | input | 3 | Block index |
| req_data | input | 32 | Writeback data |
| cmd_valid | output | 4 | One bit per cache addressed by a command |
| cmd_kind | output | 1 | 0 invalidate, 1 update memory |
| cmd_addr | output | 3 | Block index of the command |
| ack_valid | input | 4 | Per-cache command acknowledgement |
| ack_data | input | 32 | Dirty data carried by an update-memory acknowledgement |
| rsp_valid | output | 1 | Response pulse |
| rsp_dst | output | 2 | Cache receiving the response |
| rsp_has_data | output | 1 | Response carries block data |
| rsp_data | output | 32 | Block data, zero when none |

## Verification
The controller is driven through one sequence of requests that walks a block through every directory situation. The sequence covers an empty entry, a growing set of Keepers, a single Owner, and an Owner being downgraded. So each request type meets each kind of entry, and the command mask shows whether the controller picked the right caches and the right command kind. Non-owner writebacks are followed by requests whose command mask or returned data exposes any change to memory or directory. Requests from the Owner itself separate the ownership test from the plain presence test. Responders acknowledge with different delays per cache, so a grant issued before the slowest acknowledgement is caught.

// File: rtl/dirctl_pkg.sv
package dirctl_pkg;
    typedef enum logic [1:0] {
        RQ_OWN      = 2'd0,
        RQ_OWN_DATA = 2'd1,
        RQ_KEEP     = 2'd2,
        RQ_WB       = 2'd3
    } req_kind_e;

    typedef enum logic {
        CMD_INV = 1'b0,
        CMD_UPD = 1'b1
    } cmd_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_SEND,
        ST_WAIT,
        ST_GRANT
    } state_e;
endpackage

// File: rtl/dirctl_store.sv
module dirctl_store #(
    parameter int NC = 4,
    parameter int NB = 8,
    parameter int DW = 32,
    parameter logic [31:0] INIT_BASE = 32'hA000_0000,
    localparam int AW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [NC-1:0] rd_pres,
    output logic          rd_mod,
    input  logic          mem_we,
    input  logic [AW-1:0] mem_waddr,
    input  logic [DW-1:0] mem_wdata,
    input  logic          dir_we,
    input  logic [AW-1:0] dir_waddr,
    input  logic [NC-1:0] dir_wpres,
    input  logic          dir_wmod
);
    logic [DW-1:0] mem_q  [NB];
    logic [NC-1:0] pres_q [NB];
    logic          mod_q  [NB];

    for (genvar b = 0; b < NB; b++) begin : g_blk
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem_q[b]  <= DW'(INIT_BASE) | DW'(b);
                pres_q[b] <= '0;
                mod_q[b]  <= 1'b0;
            end else begin
                if (mem_we && mem_waddr == AW'(b)) begin
                    mem_q[b] <= mem_wdata;
                end
                if (dir_we && dir_waddr == AW'(b)) begin
                    pres_q[b] <= dir_wpres;
                    mod_q[b]  <= dir_wmod;
                end
            end
        end
    end

    assign rd_data = mem_q[rd_addr];
    assign rd_pres = pres_q[rd_addr];
    assign rd_mod  = mod_q[rd_addr];

    // R3: an entry marked Modified names exactly one Owner
    p_owner_unique_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_we && dir_wmod) |-> ($countones(dir_wpres) == 1));
endmodule

// File: rtl/dirctl_ack_track.sv
module dirctl_ack_track #(
    parameter int NC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [NC-1:0] load_mask,
    input  logic [NC-1:0] ack,
    output logic          all_done
);
    logic [NC-1:0] pending_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= '0;
        end else if (load) begin
            pending_q <= load_mask;
        end else begin
            pending_q <= pending_q & ~ack;
        end
    end

    assign all_done = (pending_q == '0);

    // R5: a fresh load never starts while acknowledgements are still owed
    p_load_when_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> all_done);
endmodule

// File: rtl/dirctl_top.sv
module dirctl_top #(
    parameter int NC = 4,
    parameter int NB = 8,
    parameter int DW = 32,
    localparam int CW = $clog2(NC),
    localparam int AW = $clog2(NB)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [CW-1:0] req_src,
    input  logic [1:0]    req_kind,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic [NC-1:0] cmd_valid,
    output logic          cmd_kind,
    output logic [AW-1:0] cmd_addr,
    input  logic [NC-1:0] ack_valid,
    input  logic [DW-1:0] ack_data,
    output logic          rsp_valid,
    output logic [CW-1:0] rsp_dst,
    output logic          rsp_has_data,
    output logic [DW-1:0] rsp_data
);
    import dirctl_pkg::*;

    state_e        st_q, st_nx;
    logic [CW-1:0] src_q;
    req_kind_e     kind_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [NC-1:0] tgt_q;
    cmd_kind_e     ck_q;

    logic [DW-1:0] rd_data;
    logic [NC-1:0] rd_pres;
    logic          rd_mod;
    logic          mem_we, dir_we, dir_wmod;
    logic [DW-1:0] mem_wdata;
    logic [NC-1:0] dir_wpres;
    logic          trk_load, trk_done;

    logic [NC-1:0] src_bit;
    logic          is_owner;
    logic          lk_send;
    logic [NC-1:0] lk_tgt;
    cmd_kind_e     lk_ck;

    dirctl_store #(.NC(NC), .NB(NB), .DW(DW)) store_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr  (addr_q),
        .rd_data  (rd_data),
        .rd_pres  (rd_pres),
        .rd_mod   (rd_mod),
        .mem_we   (mem_we),
        .mem_waddr(addr_q),
        .mem_wdata(mem_wdata),
        .dir_we   (dir_we),
        .dir_waddr(addr_q),
        .dir_wpres(dir_wpres),
        .dir_wmod (dir_wmod)
    );

    dirctl_ack_track #(.NC(NC)) track_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (trk_load),
        .load_mask(tgt_q),
        .ack      (ack_valid),
        .all_done (trk_done)
    );

    assign src_bit  = NC'(1) << src_q;
    assign is_owner = rd_mod && (|(rd_pres & src_bit));

    // Decision taken in LOOKUP from the directory entry of the held request
    always_comb begin
        lk_send = 1'b0;
        lk_tgt  = '0;
        lk_ck   = CMD_INV;
        unique case (kind_q)
            RQ_OWN, RQ_OWN_DATA: begin
                lk_tgt  = rd_pres & ~src_bit;
                lk_send = |lk_tgt;
            end
            RQ_KEEP: begin
                if (rd_mod && !is_owner) begin
                    lk_tgt  = rd_pres;
                    lk_ck   = CMD_UPD;
                    lk_send = 1'b1;
                end
            end
            RQ_WB: begin
                lk_send = 1'b0;
            end
        endcase
    end

    // State register and request holding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            src_q   <= '0;
            kind_q  <= RQ_OWN;
            addr_q  <= '0;
            wdata_q <= '0;
            tgt_q   <= '0;
            ck_q    <= CMD_INV;
        end else begin
            st_q <= st_nx;
            if (st_q == ST_IDLE && req_valid) begin
                src_q   <= req_src;
                kind_q  <= req_kind_e'(req_kind);
                addr_q  <= req_addr;
                wdata_q <= req_data;
            end
            if (st_q == ST_LOOKUP) begin
                tgt_q <= lk_tgt;
                ck_q  <= lk_ck;
            end
        end
    end

    // Transitions
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            ST_IDLE:   if (req_valid) st_nx = ST_LOOKUP;
            ST_LOOKUP: st_nx = lk_send ? ST_SEND : ST_GRANT;
            ST_SEND:   st_nx = ST_WAIT;
            ST_WAIT:   if (trk_done) st_nx = ST_GRANT;
            ST_GRANT:  st_nx = ST_IDLE;
            default:   st_nx = ST_IDLE;
        endcase
    end

    // Outputs and directory/memory updates
    always_comb begin
        req_ready    = (st_q == ST_IDLE);
        cmd_valid    = '0;
        cmd_kind     = ck_q;
        cmd_addr     = addr_q;
        rsp_valid    = 1'b0;
        rsp_dst      = src_q;
        rsp_has_data = 1'b0;
        rsp_data     = '0;
        trk_load     = 1'b0;
        mem_we       = 1'b0;
        mem_wdata    = ack_data;
        dir_we       = 1'b0;
        dir_wpres    = rd_pres;
        dir_wmod     = 1'b0;
        unique case (st_q)
            ST_SEND: begin
                cmd_valid = tgt_q;
                trk_load  = 1'b1;
            end
            ST_WAIT: begin
                if (ck_q == CMD_UPD && (|(ack_valid & tgt_q))) begin
                    mem_we    = 1'b1;
                    mem_wdata = ack_data;
                    dir_we    = 1'b1;
                    dir_wpres = rd_pres;
                    dir_wmod  = 1'b0;
                end
            end
            ST_GRANT: begin
                rsp_valid = 1'b1;
                unique case (kind_q)
                    RQ_OWN, RQ_OWN_DATA: begin
                        dir_we    = 1'b1;
                        dir_wpres = src_bit;
                        dir_wmod  = 1'b1;
                        if (kind_q == RQ_OWN_DATA) begin
                            rsp_has_data = 1'b1;
                            rsp_data     = rd_data;
                        end
                    end
                    RQ_KEEP: begin
                        rsp_has_data = 1'b1;
                        rsp_data     = rd_data;
                        if (!is_owner) begin
                            dir_we    = 1'b1;
                            dir_wpres = rd_pres | src_bit;
                            dir_wmod  = 1'b0;
                        end
                    end
                    RQ_WB: begin
                        if (is_owner) begin
                            mem_we    = 1'b1;
                            mem_wdata = wdata_q;
                            dir_we    = 1'b1;
                            dir_wpres = rd_pres & ~src_bit;
                            dir_wmod  = 1'b0;
                        end
                    end
                endcase
            end
            default: begin
                cmd_valid = '0;
            end
        endcase
    end

    // R9: acceptance closes the request port
    p_accept_stalls_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R5: commands last a single cycle
    p_cmd_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (|cmd_valid) |=> (cmd_valid == '0));

    // R5: no response while acknowledgements are outstanding
    p_grant_after_acks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> trk_done);

    // R3: the requester never receives its own command
    p_no_self_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|cmd_valid) |-> ((cmd_valid & src_bit) == '0));

    // R6: an update-memory command addresses a single cache
    p_update_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((|cmd_valid) && cmd_kind) |-> ($countones(cmd_valid) == 1));
endmodule

// File: tb/dirctl_top_tb_top.sv
`timescale 1ns/1ps
module dirctl_top_tb_top;
    localparam int NC = 4;
    localparam int NB = 8;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_src = '0;
    logic [1:0]    req_kind = '0;
    logic [2:0]    req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [NC-1:0] cmd_valid;
    logic          cmd_kind;
    logic [2:0]    cmd_addr;
    logic [NC-1:0] ack_valid = '0;
    logic [DW-1:0] ack_data = '0;
    logic          rsp_valid;
    logic [1:0]    rsp_dst;
    logic          rsp_has_data;
    logic [DW-1:0] rsp_data;

    always #2 clk = ~clk;

    dirctl_top #(.NC(NC), .NB(NB), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_src(req_src),
        .req_kind(req_kind), .req_addr(req_addr), .req_data(req_data),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
        .ack_valid(ack_valid), .ack_data(ack_data),
        .rsp_valid(rsp_valid), .rsp_dst(rsp_dst),
        .rsp_has_data(rsp_has_data), .rsp_data(rsp_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int last_ack_cyc = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Cache responders: cache i acknowledges i+1 cycles after its command
    int      cnt   [NC];
    logic    ckind [NC];
    logic [2:0] caddr [NC];
    initial for (int i = 0; i < NC; i++) begin cnt[i] = 0; ckind[i] = 1'b0; caddr[i] = '0; end

    always @(negedge clk) begin
        ack_valid = '0;
        for (int i = 0; i < NC; i++) begin
            if (cnt[i] > 0) begin
                cnt[i] = cnt[i] - 1;
                if (cnt[i] == 0) begin
                    ack_valid[i] = 1'b1;
                    last_ack_cyc = cyc;
                    if (ckind[i]) ack_data = 32'hC0DE_0000 | (32'(i) << 8) | 32'(caddr[i]);
                end
            end
            if (cmd_valid[i]) begin
                cnt[i]   = i + 1;
                ckind[i] = cmd_kind;
                caddr[i] = cmd_addr;
            end
        end
    end

    task automatic check(input bit ok, input int rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    typedef struct packed {
        logic [1:0]  src;
        logic [1:0]  kind;
        logic [2:0]  addr;
        logic [31:0] wdata;
        logic [3:0]  emask;
        logic        ekind;
        logic        ehd;
        logic [31:0] edata;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 2'd2, 3'd1, 32'h0,         4'b0000, 1'b0, 1'b1, 32'hA000_0001, 4'd2},  // R2 R1
        '{2'd1, 2'd2, 3'd1, 32'h0,         4'b0000, 1'b0, 1'b1, 32'hA000_0001, 4'd2},  // R2
        '{2'd2, 2'd0, 3'd1, 32'h0,         4'b0011, 1'b0, 1'b0, 32'h0,         4'd3},  // R3
        '{2'd3, 2'd2, 3'd1, 32'h0,         4'b0100, 1'b1, 1'b1, 32'hC0DE_0201, 4'd6},  // R6
        '{2'd0, 2'd1, 3'd1, 32'h0,         4'b1100, 1'b0, 1'b1, 32'hC0DE_0201, 4'd4},  // R4
        '{2'd1, 2'd3, 3'd1, 32'h1234_5678, 4'b0000, 1'b0, 1'b0, 32'h0,         4'd8},  // R8
        '{2'd2, 2'd2, 3'd1, 32'h0,         4'b0001, 1'b1, 1'b1, 32'hC0DE_0001, 4'd8},  // R8 directory kept
        '{2'd0, 2'd0, 3'd1, 32'h0,         4'b0100, 1'b0, 1'b0, 32'h0,         4'd3},  // R3
        '{2'd0, 2'd3, 3'd1, 32'h0BAD_F00D, 4'b0000, 1'b0, 1'b0, 32'h0,         4'd7},  // R7
        '{2'd2, 2'd2, 3'd1, 32'h0,         4'b0000, 1'b0, 1'b1, 32'h0BAD_F00D, 4'd7},  // R7
        '{2'd1, 2'd3, 3'd3, 32'h1234_5678, 4'b0000, 1'b0, 1'b0, 32'h0,         4'd8},  // R8
        '{2'd0, 2'd2, 3'd3, 32'h0,         4'b0000, 1'b0, 1'b1, 32'hA000_0003, 4'd8},  // R8 memory kept
        '{2'd3, 2'd0, 3'd2, 32'h0,         4'b0000, 1'b0, 1'b0, 32'h0,         4'd10}, // R10
        '{2'd3, 2'd1, 3'd2, 32'h0,         4'b0000, 1'b0, 1'b1, 32'hA000_0002, 4'd10}, // R10
        '{2'd3, 2'd2, 3'd2, 32'h0,         4'b0000, 1'b0, 1'b1, 32'hA000_0002, 4'd10}, // R10
        '{2'd1, 2'd2, 3'd2, 32'h0,         4'b1000, 1'b1, 1'b1, 32'hC0DE_0302, 4'd6},  // R6
        '{2'd1, 2'd1, 3'd2, 32'h0,         4'b1000, 1'b0, 1'b1, 32'hC0DE_0302, 4'd4}   // R4 R6 keeper kept
    };

    task automatic run_vec(input vec_t v);
        logic [NC-1:0] seen_mask = '0;
        logic          seen_kind = 1'b0;
        logic [2:0]    seen_addr = '0;
        bit            ready_ok = 1'b1;
        int            guard = 0;
        int            rsp_cyc;
        @(negedge clk);
        req_valid = 1'b1;
        req_src   = v.src;
        req_kind  = v.kind;
        req_addr  = v.addr;
        req_data  = v.wdata;
        last_ack_cyc = 0;
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid && guard < 100) begin
            if (req_ready) ready_ok = 1'b0;
            if (|cmd_valid) begin
                seen_mask = seen_mask | cmd_valid;
                seen_kind = cmd_kind;
                seen_addr = cmd_addr;
            end
            @(negedge clk);
            guard++;
        end
        rsp_cyc = cyc;
        check(rsp_valid, int'(v.rq), "response given", 32'(rsp_valid), 32'h1);
        check(ready_ok && !req_ready, 9, "req_ready low while busy (R9)", 32'(ready_ok), 32'h1);
        check(seen_mask == v.emask, int'(v.rq), "command mask", 32'(seen_mask), 32'(v.emask));
        if (v.emask != '0) begin
            check(seen_kind == v.ekind, int'(v.rq), "command kind", 32'(seen_kind), 32'(v.ekind));
            check(seen_addr == v.addr, int'(v.rq), "command addr", 32'(seen_addr), 32'(v.addr));
            check(rsp_cyc > last_ack_cyc, 5, "response after last ack (R5)",
                  32'(rsp_cyc), 32'(last_ack_cyc + 1));
        end
        check(rsp_dst == v.src, int'(v.rq), "response destination", 32'(rsp_dst), 32'(v.src));
        check(rsp_has_data == v.ehd, int'(v.rq), "response has data", 32'(rsp_has_data), 32'(v.ehd));
        check(rsp_data == v.edata, int'(v.rq), "response data", rsp_data, v.edata);
        @(negedge clk);
        check(req_ready, 9, "ready again after response (R9)", 32'(req_ready), 32'h1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        check(req_ready == 1'b1, 1, "reset req_ready", 32'(req_ready), 32'h1);
        check(cmd_valid == '0, 1, "reset cmd_valid", 32'(cmd_valid), 32'h0);
        check(rsp_valid == 1'b0, 1, "reset rsp_valid", 32'(rsp_valid), 32'h0);
        for (int k = 0; k < NV; k++) run_vec(VEC[k]);
        // R1: an untouched block still holds its reset value, no owner
        run_vec('{2'd2, 2'd1, 3'd7, 32'h0, 4'b0000, 1'b0, 1'b1, 32'hA000_0007, 4'd1});
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule